// File: doc/BRIEF.md
# Enable-Framed Serial Command Byte Receiver

This block receives one command byte at a time over a three-wire serial link made of a data line, a serial clock and an active-low enable. While the enable is held low, each rising edge of the serial clock shifts one data bit into the receiver, most significant bit first. When the enable returns high, a complete byte is handed to the register bank. The block presents it as a parallel value, together with a strobe that lasts one system clock.

The three serial inputs are asynchronous to the system clock. The block brings them into the system clock domain through synchroniser chains and detects their edges there, so the system clock must run well above the serial clock. A serial clock of up to 1 MHz, high and low for at least 500 ns each, is covered by a system clock of 16 MHz or more. The block enforces the frame rules itself. If the enable is released before eight bits have arrived, the frame is discarded. Bits clocked in after the eighth are dropped. The byte takes effect only when the enable is released.

Top module: `spi_cmd_rx`

## Requirements
- R1: Data is sampled on rising serial clock edges while enable is low, and the first bit received becomes bit 7 of the delivered byte, the last becomes bit 0.
- R2: A frame of exactly eight rising serial clock edges followed by enable going high produces exactly one strobe, with the received byte on `cmd_o`.
- R3: Serial clock edges after the eighth in a frame do not change the delivered byte: the first eight bits are kept.
- R4: A frame that ends with fewer than eight bits produces no strobe, and `cmd_o` keeps the value of the last delivered byte.
- R5: `cmd_valid_o` stays high for exactly one system clock per delivered byte.
- R6: Serial clock edges while enable is high produce no strobe and leave `cmd_o` unchanged.
- R7: The bit count restarts on every enable falling edge, so a complete frame that follows an aborted one is delivered correctly.
- R8: After reset, `cmd_o` is 0 and `cmd_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, data sampled on its rising edge |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_en_n_i | input | 1 | Active-low frame enable |
| cmd_o | output | 8 | Last delivered command byte |
| cmd_valid_o | output | 1 | One-cycle strobe when `cmd_o` is updated |

## Verification
The bench builds the block with its default 8-bit byte and a two-stage synchroniser. At that size, every one of the 256 byte values can be sent as a complete frame and compared with the value computed in the bench. Frames are also cut short at every length from zero to seven bits and extended by one to four extra bits. This exercises each saturation and abort boundary of the bit counter. Serial clock activity with the enable high, and an aborted frame followed directly by a full frame, cover the idle and restart paths.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int DEF_BYTE_W = 8;
  localparam int DEF_SYNC_STAGES = 2;

  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_rx_frame.sv
module spi_rx_frame
  import spi_rx_pkg::*;
#(
  parameter int BYTE_W = DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              dat_s,
  input  logic              en_n_s,
  output logic              en_rise_o,
  output logic              full_o,
  output logic [BYTE_W-1:0] shreg_o
);
  localparam int CNT_W = cnt_width(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BYTE_W);

  logic              sclk_q, en_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic              sclk_rise, en_fall, shift_en;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign en_fall   = en_q & ~en_n_s;
  assign shift_en  = sclk_rise & ~en_n_s & (cnt_q != CNT_MAX);

  always_comb begin
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    if (en_fall) begin
      cnt_d = '0;
    end else if (shift_en) begin
      cnt_d   = cnt_q + 1'b1;
      shreg_d = {shreg_q[BYTE_W-2:0], dat_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      en_q    <= 1'b1;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else begin
      sclk_q  <= sclk_s;
      en_q    <= en_n_s;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
    end
  end

  assign en_rise_o = ~en_q & en_n_s;
  assign full_o    = (cnt_q == CNT_MAX);
  assign shreg_o   = shreg_q;

  assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= BYTE_W);
  assert_extra_bits_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && sclk_rise && !en_fall) |=> $stable(shreg_q));
  assert_idle_clock_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n_s && en_q && sclk_rise) |=> ($stable(shreg_q) && $stable(cnt_q)));
endmodule

// File: rtl/spi_rx_commit.sv
module spi_rx_commit
  import spi_rx_pkg::*;
#(
  parameter int BYTE_W = DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_rise_i,
  input  logic              full_i,
  input  logic [BYTE_W-1:0] shreg_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o
);
  logic [BYTE_W-1:0] data_q, data_d;
  logic              valid_q, valid_d;
  logic              load;

  assign load = en_rise_i & full_i;

  always_comb begin
    data_d  = data_q;
    valid_d = 1'b0;
    if (load) begin
      data_d  = shreg_i;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  assert_strobe_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  assert_only_full_frames_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(full_i));
  assert_hold_without_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(data_q));
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_rx_pkg::*;
#(
  parameter int BYTE_W      = DEF_BYTE_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_en_n_i,
  output logic [BYTE_W-1:0] cmd_o,
  output logic              cmd_valid_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [2:0]        pins_s;
  logic              en_rise, full;
  logic [BYTE_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  spi_rx_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) i_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .async_i({ser_en_n_i, ser_dat_i, ser_clk_i}),
    .sync_o (pins_s)
  );

  spi_rx_frame #(.BYTE_W(BYTE_W)) i_frame (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sclk_s   (pins_s[0]),
    .dat_s    (pins_s[1]),
    .en_n_s   (pins_s[2]),
    .en_rise_o(en_rise),
    .full_o   (full),
    .shreg_o  (shreg)
  );

  spi_rx_commit #(.BYTE_W(BYTE_W)) i_commit (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en_rise_i(en_rise),
    .full_i   (full),
    .shreg_i  (shreg),
    .data_o   (cmd_o),
    .valid_o  (cmd_valid_o)
  );
endmodule

// File: tb/test_spi_cmd_rx.sv
`timescale 1ns/1ps
module test_spi_cmd_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_dat = 1'b0;
  logic       ser_en_n = 1'b1;
  logic [7:0] cmd;
  logic       cmd_valid;

  int tests = 0;
  int fails = 0;
  int pulses = 0;
  int wide = 0;
  logic prev_valid = 1'b0;
  logic [7:0] last_cmd = 8'h00;
  logic [7:0] held;

  always #2.5 clk = ~clk;

  spi_cmd_rx i_spi_cmd_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_en_n_i(ser_en_n), .cmd_o(cmd), .cmd_valid_o(cmd_valid)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin
      pulses++;
      last_cmd = cmd;
      if (prev_valid) wide++;
    end
    prev_valid = cmd_valid;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Sends nbits bits taken MSB first from a 16-bit pattern, then releases.
  task automatic frame(input logic [15:0] pat, input int nbits);
    pulses = 0;
    wide = 0;
    ser_en_n = 1'b0;
    #40;
    for (int i = 0; i < nbits; i++) begin
      ser_dat = pat[15-i];
      #40 ser_clk = 1'b1;
      #40 ser_clk = 1'b0;
    end
    #40 ser_en_n = 1'b1;
    #120;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #23 rst_n = 1'b1;
    #20;
    @(negedge clk);
    check(cmd == 8'h00, "R8 reset cmd", cmd, 0);
    check(cmd_valid == 1'b0, "R8 reset valid", cmd_valid, 0);

    for (int b = 0; b < 256; b++) begin
      frame({b[7:0], 8'h00}, 8);
      check(pulses == 1, "R2 one strobe", pulses, 1);
      check(last_cmd == b[7:0] && cmd == b[7:0], "R1 byte order", cmd, b);
      check(wide == 0, "R5 strobe width", wide, 0);
    end

    for (int n = 0; n < 8; n++) begin
      held = cmd;
      frame(16'hA5C3 ^ {n[7:0], 8'h00}, n);
      check(pulses == 0, "R4 abort no strobe", pulses, 0);
      check(cmd == held, "R4 abort hold", cmd, held);
    end

    for (int x = 1; x <= 4; x++) begin
      logic [7:0] v;
      v = 8'h3C + 8'(x * 17);
      frame({v, ~v}, 8 + x);
      check(pulses == 1, "R3 extra bits strobe", pulses, 1);
      check(cmd == v, "R3 first eight kept", cmd, v);
    end

    held = cmd;
    pulses = 0;
    for (int i = 0; i < 6; i++) begin
      ser_dat = i[0];
      #40 ser_clk = 1'b1;
      #40 ser_clk = 1'b0;
    end
    #120;
    check(pulses == 0, "R6 idle clocks strobe", pulses, 0);
    check(cmd == held, "R6 idle clocks hold", cmd, held);

    frame(16'hFFFF, 5);
    check(pulses == 0, "R7 aborted lead-in", pulses, 0);
    frame(16'h6900, 8);
    check(pulses == 1 && cmd == 8'h69, "R7 restart after abort", cmd, 8'h69);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule